// File: doc/BRIEF.md
# Dual-Channel Per-Thread Compare Timer

This block holds two independent count/compare channels behind a 32-bit word-addressed register interface, one channel for each hardware thread context of a processor. Each channel owns a free-running counter that advances by one every clock and a compare register. When the counter equals the compare value, the channel sets a sticky pending flag. The flags of both channels, each gated by its own enable bit, are ORed into a single interrupt line. Software reads one shared control register to learn which channel fired.

Software arms a one-shot event on a channel by reading that channel's counter and writing compare = count + delta. The sum wraps modulo the counter width. Writing the compare register also clears that channel's stale pending flag, so arming and acknowledging take a single write. A pending flag can also be cleared on its own by writing a one to its bit in the control register. Counters may be preset by writing them.

Top module: `dct_timer`

## Requirements
- R1: Word addresses decode as 0 = control, 1 = compare of channel 0, 2 = count of channel 0, 3 = compare of channel 1, 4 = count of channel 1. Any other address reads zero, and a write to it changes no register.
- R2: Each counter advances by one per clock when it is not being written, and wraps from 2^CNT_W-1 to 0.
- R3: A write to a count register loads the low CNT_W bits of the write data at that clock edge. The counter then advances by one per clock from that value.
- R4: A compare register stores the low CNT_W bits of the write data. Reads return that value zero-extended.
- R5: A channel's pending flag becomes set at the first clock edge at which its counter equals its compare register. This happens whatever the enable bit is. The flag then holds until cleared. Pending flags read at control bit 16 (channel 0) and bit 17 (channel 1).
- R6: Writing a channel's compare register clears its pending flag. This clear wins over a match in the same cycle.
- R7: Writing control with a one at bit 16+ch clears that channel's pending flag. A zero at that bit leaves the flag unchanged.
- R8: Control bits 0 and 1 enable channels 0 and 1. The irq output is a register that holds the OR of (pending AND enable) over the channels. It rises one clock after the pending flag sets.
- R9: While reset is high, every counter, compare register, enable, pending flag, irq and rd_data is zero. Because count equals compare after reset, both pending flags set at the first clock edge after reset is released.
- R10: rd_data is registered. After a clock edge it holds the value that the register selected by rd_addr had just before that edge.
- R11: Control bits other than the enable and pending bits always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with two channels and an 8-bit counter. At that width a counter wraps every 256 clocks, so every arming delta from 1 to 255 can be swept on both channels with a wrapping start count. Each sweep checks, cycle by cycle, the exact edge at which the pending flag and irq appear. Enable is off for every third delta, which shows that the flag sets without the interrupt. The wrap from 0xFE through 0x00, the address holes, the reserved control bits and both clear paths are each reached in a few cycles.

// File: rtl/dct_pkg.sv
package dct_pkg;
  // control register layout
  localparam int PEND_LSB = 16;

  // word index of a channel's compare and count registers
  function automatic int cmp_index(input int ch);
    return 1 + 2 * ch;
  endfunction

  function automatic int cnt_index(input int ch);
    return 2 + 2 * ch;
  endfunction
endpackage

// File: rtl/dct_decode.sv
module dct_decode #(
  parameter int N_CH   = 2,
  parameter int ADDR_W = 3
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              ctrl_we,
  output logic [N_CH-1:0]   cmp_we,
  output logic [N_CH-1:0]   cnt_we
);
  import dct_pkg::*;

  assign ctrl_we = wr_en && (wr_addr == '0);

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_dec
    assign cmp_we[ch] = wr_en && (wr_addr == ADDR_W'(cmp_index(ch)));
    assign cnt_we[ch] = wr_en && (wr_addr == ADDR_W'(cnt_index(ch)));
  end
endmodule

// File: rtl/dct_channel.sv
module dct_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_we,
  input  logic             cmp_we,
  input  logic             pend_clr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             pend_q
);
  logic match;
  assign match = (cnt_q == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q <= cnt_we ? wdata : cnt_q + 1'b1;
      if (cmp_we) cmp_q <= wdata;
      // re-arm beats match, match beats software clear
      if (cmp_we)        pend_q <= 1'b0;
      else if (match)    pend_q <= 1'b1;
      else if (pend_clr) pend_q <= 1'b0;
    end
  end

  a_r2_count_advances: assert property (@(posedge clk) disable iff (rst)
    !cnt_we |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r3_count_preset: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> cnt_q == $past(wdata));
  a_r5_match_sets: assert property (@(posedge clk) disable iff (rst)
    (match && !cmp_we) |=> pend_q);
  a_r6_rearm_clears: assert property (@(posedge clk) disable iff (rst)
    cmp_we |=> !pend_q);
endmodule

// File: rtl/dct_readmux.sv
module dct_readmux #(
  parameter int N_CH   = 2,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic [DATA_W-1:0]          ctrl_word,
  input  logic [N_CH-1:0][CNT_W-1:0] cnt_all,
  input  logic [N_CH-1:0][CNT_W-1:0] cmp_all,
  output logic [DATA_W-1:0]          rd_data
);
  import dct_pkg::*;
  localparam int LAST_ADDR = 2 * N_CH;

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (rd_addr == '0) sel = ctrl_word;
    for (int ch = 0; ch < N_CH; ch++) begin
      if (rd_addr == ADDR_W'(cmp_index(ch))) sel = DATA_W'(cmp_all[ch]);
      if (rd_addr == ADDR_W'(cnt_index(ch))) sel = DATA_W'(cnt_all[ch]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= sel;
  end

  a_r1_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_addr > ADDR_W'(LAST_ADDR)) |=> rd_data == '0);
endmodule

// File: rtl/dct_timer.sv
module dct_timer #(
  parameter int N_CH   = 2,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(2 * N_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  import dct_pkg::*;

  logic                       ctrl_we;
  logic [N_CH-1:0]            cmp_we, cnt_we, pend, en_q;
  logic [N_CH-1:0][CNT_W-1:0] cnt_all, cmp_all;
  logic [DATA_W-1:0]          ctrl_word;
  logic                       unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  dct_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_decode (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .ctrl_we(ctrl_we),
    .cmp_we (cmp_we),
    .cnt_we (cnt_we)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    dct_channel #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .cnt_we  (cnt_we[ch]),
      .cmp_we  (cmp_we[ch]),
      .pend_clr(ctrl_we && wr_data[PEND_LSB + ch]),
      .wdata   (wr_data[CNT_W-1:0]),
      .cnt_q   (cnt_all[ch]),
      .cmp_q   (cmp_all[ch]),
      .pend_q  (pend[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      irq  <= 1'b0;
    end else begin
      if (ctrl_we) en_q <= wr_data[N_CH-1:0];
      irq <= |(pend & en_q);
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[N_CH-1:0] = en_q;
    ctrl_word[PEND_LSB +: N_CH] = pend;
  end

  dct_readmux #(
    .N_CH(N_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_readmux (
    .clk      (clk),
    .rst      (rst),
    .rd_addr  (rd_addr),
    .ctrl_word(ctrl_word),
    .cnt_all  (cnt_all),
    .cmp_all  (cmp_all),
    .rd_data  (rd_data)
  );

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !(|en_q) |=> !irq);
  a_r8_no_irq_without_pending: assert property (@(posedge clk) disable iff (rst)
    !(|pend) |=> !irq);
endmodule

// File: tb/test_dct_timer.sv
module test_dct_timer;
  localparam int N_CH = 2;
  localparam int CNT_W = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dct_timer #(.N_CH(N_CH), .CNT_W(CNT_W), .DATA_W(32)) i_dct_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [AW-1:0] cmpa(input int ch);
    return AW'(1 + 2 * ch);
  endfunction
  function automatic logic [AW-1:0] cnta(input int ch);
    return AW'(2 + 2 * ch);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  // arm channel ch with start count c and delta d, then follow it edge by edge
  task automatic arm(input int ch, input int c, input int d, input bit en);
    logic [31:0] en_word, pbit;
    en_word = en ? (32'h1 << ch) : 32'h0;
    pbit = 32'h1 << (16 + ch);
    rd_addr = '0;
    wr(3'd0, en_word | pbit);
    wr(cnta(ch), 32'(c & 255));            // edge e0
    wr(cmpa(ch), 32'((c + d) & 255));      // edge e0+1
    for (int n = 2; n <= d + 3; n++) begin
      step();
      chk("R5", (rd_data >> (16 + ch)) & 32'h1, (n >= d + 2) ? 32'h1 : 32'h0);
      chk("R8", {31'b0, irq}, (en && n >= d + 2) ? 32'h1 : 32'h0);
    end
    wr(3'd0, en_word);
    step();
    chk("R7 zero leaves", (rd_data >> (16 + ch)) & 32'h1, 32'h1);
    if (d % 2 == 1) begin
      wr(cmpa(ch), 32'((c + d + 100) & 255));
      step();
      chk("R6", (rd_data >> (16 + ch)) & 32'h1, 32'h0);
    end else begin
      wr(3'd0, en_word | pbit);
      step();
      chk("R7", (rd_data >> (16 + ch)) & 32'h1, 32'h0);
    end
    chk("R8 after clear", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9 reset state
    rd_addr = cnta(0);
    repeat (3) @(negedge clk);
    chk("R9 rd_data", rd_data, 32'h0);
    chk("R9 irq", {31'b0, irq}, 32'h0);
    rst = 1'b0;
    step();
    chk("R9 count", rd_data, 32'h0);
    step();
    chk("R2 count+1", rd_data, 32'h1);
    step();
    chk("R2 count+2", rd_data, 32'h2);
    rd_addr = '0;
    step();
    chk("R9 pending after reset", rd_data, 32'h0003_0000);
    chk("R9 irq disabled", {31'b0, irq}, 32'h0);

    // R4 compare readback, upper bits dropped
    wr(cmpa(1), 32'hABCD_1234);
    rd_addr = cmpa(1);
    step();
    chk("R4", rd_data, 32'h0000_0034);

    // R3 preset and R2 wraparound, R10 read latency
    rd_addr = cnta(1);
    wr(cnta(1), 32'h0000_00FE);
    step();
    chk("R3", rd_data, 32'hFE);
    step();
    chk("R2 FF", rd_data, 32'hFF);
    step();
    chk("R2 wrap", rd_data, 32'h00);

    // R1 holes
    for (int a = 5; a < 8; a++) begin
      rd_addr = AW'(a);
      step();
      chk("R1 hole read", rd_data, 32'h0);
    end
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd_addr = '0;
    step();
    chk("R1 hole write", rd_data & 32'h3, 32'h0);

    // R11 reserved bits
    wr(3'd0, 32'hFFFF_FFFF);
    step();
    chk("R11", rd_data & ~32'h0003_0003, 32'h0);
    chk("R8 enables", rd_data & 32'h3, 32'h3);
    wr(3'd0, 32'h0003_0000);

    // sweep every delta on both channels
    for (int ch = 0; ch < N_CH; ch++) begin
      for (int d = 1; d < 256; d++) begin
        arm(ch, (d * 37 + 200 + ch) & 255, d, (d % 3) != 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule